// File: doc/BRIEF.md
# Periodic Down-Counting Interrupt Timer

This block is a bus-programmed timer. A down counter loses one count per prescaled tick. When the counter value equals a programmed compare value on a tick, a sticky event flag is set. An interrupt line is driven high while that flag is set and the interrupt is enabled. The tick comes from one of three external tick-enable inputs, picked by a select field in the control word. The prescaler divides the selected ticks by a programmable amount.

Software sets the period by writing a start value and a compare value. It then picks one of two behaviours at zero: the counter either restarts from the start value, or wraps to all ones and keeps counting down. Last, software sets the enable bit. If the enable-load option is set, the counter is loaded from the start value when counting is enabled. Software clears the flag by writing one to the status word.

Top module: `irq_down_timer`

## Requirements
- R1: After reset, every register, the counter, the irq output and the read data are all zero.
- R2: The counter holds and no event occurs while control bit 0 (run) is clear or the source field (control bits 25:24) is zero. Either condition also restarts the prescaler from zero.
- R3: Control bits 15:4 hold a divide value D. The counter decrements once for every D+1 cycles in which the selected source tick is high. A divide value lowered mid-run takes effect without a long stall.
- R4: An event occurs on a tick where the counter value before the decrement equals the compare register (word address 3). With compare 0, this gives one event per count-out.
- R5: With control bit 3 (restart) set, a tick at count zero reloads the counter from the start register (word address 2). With start value L, the period is L+1 ticks.
- R6: With control bit 3 clear, a tick at count zero sets the counter to all ones, and counting down continues.
- R7: A control write that sets bit 0 while it was clear, with bit 1 (enable-load) set in the written word, loads the counter from the start register. Without bit 1, the counter resumes from its held value.
- R8: Status word (address 1) bit 0 is the event flag. It stays set until software writes one to that bit. Writing zero to it changes nothing.
- R9: An event in the same cycle as a write-one-to-clear leaves the flag set.
- R10: irq is high exactly when the flag is set and control bit 2 (interrupt enable) is set.
- R11: A write to the start register while bit 3 is set loads the counter at once. In that cycle, any tick produces no event.
- R12: Source field value s (1 to 3) selects src_tick[s-1]. Control bits read back as written. The status word reads as 31 zero bits above the flag. A read strobe returns data on the next cycle, and bus_rdata holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Word address: 0 control, 1 status, 2 start, 3 compare |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_tick | input | 3 | Tick enables of the three selectable sources |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the strobes, address and tick inputs carry known values after reset. They also assume that a read and a write never arrive in the same cycle, so that read data always reflects the registers before any write.

The stimulus issues at most one bus operation per cycle, chosen at random or directed. It keeps start, compare and divide values small so that wrap, reload and prescaler terminal counts all occur within the run. It also mixes in an all-ones compare value so that the wrap path produces events.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_STAT = 2'd1;
  localparam logic [1:0] ADR_LOAD = 2'd2;
  localparam logic [1:0] ADR_CMP  = 2'd3;

  localparam int B_RUN  = 0;
  localparam int B_LDEN = 1;
  localparam int B_IE   = 2;
  localparam int B_RLD  = 3;
  localparam int DIV_LSB = 4;
  localparam int SEL_LSB = 24;
  localparam int SEL_W   = 2;
endpackage

// File: rtl/tmr_presc.sv
module tmr_presc #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             src_hit,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] pre_q;

  assign tick = active && src_hit && (pre_q >= div);

  always_ff @(posedge clk) begin
    if (rst || !active) pre_q <= '0;
    else if (src_hit)   pre_q <= tick ? '0 : pre_q + 1'b1;
  end

  AST_PRE_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !active |=> (pre_q == '0)); // R2
  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (active && !src_hit) |=> $stable(pre_q)); // R3
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             reload,
  input  logic             ld_req,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] load_q,
  input  logic [CNT_W-1:0] cmp_q,
  output logic             evt
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign evt     = tick && !ld_req && (cnt_q == cmp_q);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (ld_req) cnt_q <= ld_val;
    else if (tick) begin
      if (!at_zero)    cnt_q <= cnt_q - 1'b1;
      else if (reload) cnt_q <= load_q;
      else             cnt_q <= '1;
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld_req) |=> $stable(cnt_q)); // R2
  AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_req && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
  AST_RESTART: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_req && at_zero && reload) |=> (cnt_q == $past(load_q))); // R5
  AST_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_req && at_zero && !reload) |=> (cnt_q == '1)); // R6
  AST_LOAD_NOW: assert property (@(posedge clk) disable iff (rst)
    ld_req |=> (cnt_q == $past(ld_val))); // R7
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              evt,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [CNT_W-1:0]  load_q,
  output logic [CNT_W-1:0]  cmp_q,
  output logic              flag_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              ld_req,
  output logic [CNT_W-1:0]  ld_val
);
  logic wr_ctrl, wr_stat, wr_load, wr_cmp, en_rise, ld_now, clr_req;
  logic [DATA_W-1:0] rd_v;

  assign wr_ctrl = bus_wr && (bus_addr == ADR_CTRL);
  assign wr_stat = bus_wr && (bus_addr == ADR_STAT);
  assign wr_load = bus_wr && (bus_addr == ADR_LOAD);
  assign wr_cmp  = bus_wr && (bus_addr == ADR_CMP);
  assign clr_req = wr_stat && bus_wdata[0];

  assign en_rise = wr_ctrl && bus_wdata[B_RUN] && !ctrl_q[B_RUN] && bus_wdata[B_LDEN];
  assign ld_now  = wr_load && ctrl_q[B_RLD];
  assign ld_req  = en_rise || ld_now;
  assign ld_val  = ld_now ? bus_wdata[CNT_W-1:0] : load_q;

  always_comb begin
    rd_v = '0;
    unique case (bus_addr)
      ADR_CTRL: rd_v = ctrl_q;
      ADR_STAT: rd_v[0] = flag_q;
      ADR_LOAD: rd_v[CNT_W-1:0] = load_q;
      default:  rd_v[CNT_W-1:0] = cmp_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      load_q  <= '0;
      cmp_q   <= '0;
      flag_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata;
      if (wr_load) load_q <= bus_wdata[CNT_W-1:0];
      if (wr_cmp)  cmp_q  <= bus_wdata[CNT_W-1:0];
      if (evt)          flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
      if (bus_rd) rdata_q <= rd_v;
    end
  end

  AST_W1C: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !evt) |=> !flag_q); // R8
  AST_ZERO_NOP: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !bus_wdata[0] && flag_q) |=> flag_q); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    evt |=> flag_q); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(rdata_q)); // R12
endmodule

// File: rtl/irq_down_timer.sv
module irq_down_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int DIV_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [2:0]        src_tick,
  output logic              irq
);
  localparam int N_SRC = (1 << SEL_W) - 1;

  logic [DATA_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  load_q, cmp_q, ld_val;
  logic              flag_q, ld_req, evt, tick, active, src_hit;
  logic [SEL_W-1:0]  sel;

  assign sel    = ctrl_q[SEL_LSB +: SEL_W];
  assign active = ctrl_q[B_RUN] && (sel != '0);

  always_comb begin
    src_hit = 1'b0;
    for (int i = 0; i < N_SRC; i++)
      if (sel == SEL_W'(i + 1)) src_hit = src_tick[i];
  end

  tmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .evt(evt),
    .ctrl_q(ctrl_q), .load_q(load_q), .cmp_q(cmp_q), .flag_q(flag_q),
    .rdata_q(bus_rdata), .ld_req(ld_req), .ld_val(ld_val)
  );

  tmr_presc #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst(rst), .active(active), .src_hit(src_hit),
    .div(ctrl_q[DIV_LSB +: DIV_W]), .tick(tick)
  );

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .reload(ctrl_q[B_RLD]),
    .ld_req(ld_req), .ld_val(ld_val), .load_q(load_q), .cmp_q(cmp_q),
    .evt(evt)
  );

  assign irq = flag_q && ctrl_q[B_IE];

  AST_SEL_OFF_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (sel == '0) |-> !tick); // R12
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
    (evt && ctrl_q[B_IE] && !(bus_wr && bus_addr == ADR_CTRL)) |=> irq); // R10
endmodule

// File: tb/irq_down_timer_test.sv
`timescale 1ns/1ps
module irq_down_timer_test;
  logic        clk = 0, rst = 1;
  logic        b_wr = 0, b_rd = 0;
  logic [1:0]  b_addr = 0;
  logic [31:0] b_wdata = 0, rdata;
  logic [2:0]  src = 3'b111;
  logic        irq;
  int checks = 0, fails = 0;

  logic [31:0] m_ctrl, m_load, m_cmp, m_cnt, m_rdata;
  logic [11:0] m_pre;
  logic        m_flag;

  localparam logic [31:0] RUN = 32'h1, LDEN = 32'h2, IE = 32'h4, RLD = 32'h8;
  localparam logic [31:0] S1 = 32'h0100_0000;

  always #10 clk = ~clk;

  irq_down_timer uut (
    .clk(clk), .rst(rst), .bus_wr(b_wr), .bus_rd(b_rd), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(rdata), .src_tick(src), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [1:0]  sel;
    logic        act, hit, tk, ldr, ev;
    logic [31:0] ldv;
    sel = m_ctrl[25:24];
    act = m_ctrl[0] && (sel != 0);
    hit = act ? src[int'(sel) - 1] : 1'b0;
    tk  = act && hit && (m_pre >= m_ctrl[15:4]);
    ldr = 0; ldv = m_load;
    if (b_wr && b_addr == 0 && b_wdata[0] && !m_ctrl[0] && b_wdata[1]) ldr = 1;
    if (b_wr && b_addr == 2 && m_ctrl[3]) begin ldr = 1; ldv = b_wdata; end
    ev = tk && !ldr && (m_cnt == m_cmp);
    if (b_rd)
      case (b_addr)
        0: m_rdata = m_ctrl;
        1: m_rdata = {31'b0, m_flag};
        2: m_rdata = m_load;
        default: m_rdata = m_cmp;
      endcase
    if (ldr) m_cnt = ldv;
    else if (tk) m_cnt = (m_cnt != 0) ? m_cnt - 1 : (m_ctrl[3] ? m_load : 32'hFFFF_FFFF);
    if (!act) m_pre = 0;
    else if (hit) m_pre = tk ? 12'd0 : m_pre + 12'd1;
    if (ev) m_flag = 1;
    else if (b_wr && b_addr == 1 && b_wdata[0]) m_flag = 0;
    if (b_wr && b_addr == 0) m_ctrl = b_wdata;
    if (b_wr && b_addr == 2) m_load = b_wdata;
    if (b_wr && b_addr == 3) m_cmp = b_wdata;
  endtask

  task automatic step();
    logic was_rd;
    was_rd = b_rd;
    model_step();
    @(posedge clk); #1;
    chk("R10 irq vs model", {31'b0, irq}, {31'b0, m_flag & m_ctrl[2]});
    if (was_rd) chk("R12 read data vs model", rdata, m_rdata);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    b_wr = 1; b_addr = a; b_wdata = d; step(); b_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a);
    b_rd = 1; b_addr = a; step(); b_rd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wait_irq(input int lim, output int n);
    n = 0;
    while (!irq && n < lim) begin step(); n++; end
  endtask

  task automatic quiesce();
    wr(0, 0); wr(1, 1);
  endtask

  task automatic count_irq(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin step(); if (irq) hi++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    int n, hi;
    void'($urandom(32'd1234));
    m_ctrl = 0; m_load = 0; m_cmp = 0; m_cnt = 0; m_rdata = 0; m_pre = 0; m_flag = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    chk("R1 irq after reset", {31'b0, irq}, 0);
    chk("R1 rdata after reset", rdata, 0);
    for (int a = 0; a < 4; a++) begin rd(2'(a)); chk("R1 register reset value", rdata, 0); end

    // R5 and R4: restart mode, start 4, compare 0
    wr(1, 1); wr(2, 4); wr(3, 0);
    wr(0, RUN | LDEN | IE | RLD | S1);
    wait_irq(50, n); chk("R5 first period", n, 5);
    wr(1, 1);
    wait_irq(50, n); chk("R5 period after clear", n, 4);

    // R3: divide by 3
    quiesce(); wr(2, 1); wr(3, 0);
    wr(0, RUN | LDEN | IE | RLD | S1 | (32'd2 << 4));
    wait_irq(50, n); chk("R3 prescaled period", n, 6);

    // R6: wrap to all ones
    quiesce(); wr(2, 2); wr(3, 32'hFFFF_FFFF);
    wr(0, RUN | LDEN | IE | S1);
    wait_irq(50, n); chk("R6 wrap reaches all ones", n, 4);
    quiesce(); wr(0, RUN | LDEN | IE | RLD | S1);
    count_irq(20, hi); chk("R5 restart never reaches all ones", hi, 0);

    // R10 and R8
    quiesce(); wr(2, 2); wr(3, 32'hFFFF_FFFF);
    wr(0, RUN | LDEN | S1);
    count_irq(6, hi); chk("R10 irq masked", hi, 0);
    rd(1); chk("R8 flag sticky", rdata, 1);
    wr(0, RUN | LDEN | IE | S1); chk("R10 irq on enable", {31'b0, irq}, 1);
    wr(1, 0); chk("R8 write zero keeps flag", {31'b0, irq}, 1);
    wr(1, 1); chk("R8 write one clears flag", {31'b0, irq}, 0);

    // R2: stopped by run bit or source field
    quiesce(); wr(2, 3); wr(3, 0);
    wr(0, LDEN | IE | RLD | S1);
    count_irq(20, hi); chk("R2 run clear holds", hi, 0);
    wr(0, RUN | LDEN | IE | RLD);
    count_irq(20, hi); chk("R2 source zero holds", hi, 0);

    // R7: resume versus load on enable
    quiesce(); wr(2, 6); wr(3, 0);
    wr(0, RUN | LDEN | IE | RLD | S1);
    idle(2);
    wr(0, LDEN | IE | RLD | S1);
    idle(5);
    wr(0, RUN | IE | RLD | S1);
    wait_irq(50, n); chk("R7 resume from held count", n, 4);
    wr(0, LDEN | IE | RLD | S1); wr(1, 1);
    wr(0, RUN | LDEN | IE | RLD | S1);
    wait_irq(50, n); chk("R7 load on enable", n, 7);

    // R11: start write in restart mode loads at once
    quiesce(); wr(2, 50); wr(3, 0);
    wr(0, RUN | LDEN | IE | RLD | S1);
    idle(3); wr(2, 2);
    wait_irq(50, n); chk("R11 immediate load", n, 3);

    // R9: event and clear in the same cycle
    quiesce(); wr(2, 3); wr(3, 0);
    wr(0, RUN | LDEN | IE | RLD | S1);
    idle(3); wr(1, 1);
    chk("R9 set wins over clear", {31'b0, irq}, 1);

    // R12: source selection and readback
    quiesce(); src = 3'b101; wr(2, 1); wr(3, 0);
    wr(0, RUN | LDEN | IE | RLD | 32'h0200_0000);
    count_irq(20, hi); chk("R12 unselected sources ignored", hi, 0);
    src = 3'b010;
    wait_irq(50, n); chk("R12 source two drives ticks", n, 2);
    src = 3'b111;
    quiesce(); wr(0, 32'hC3A5_5A70); rd(0);
    chk("R12 control readback", rdata, 32'hC3A5_5A70);
    wr(3, 32'h1357_9BDF); rd(3); chk("R12 compare readback", rdata, 32'h1357_9BDF);
    idle(2); chk("R12 read data held", rdata, 32'h1357_9BDF);

    // R4: nonzero compare
    quiesce(); wr(2, 10); wr(3, 7);
    wr(0, RUN | LDEN | IE | RLD | S1);
    wait_irq(50, n); chk("R4 compare seven", n, 4);

    // constrained random against the model
    quiesce();
    for (int c = 0; c < 3000; c++) begin
      int r;
      logic [31:0] d;
      src = 3'($urandom % 8);
      r = $urandom % 100;
      if (r < 12) begin
        b_addr = 2'($urandom % 4);
        case (b_addr)
          0: d = ($urandom & 32'hFCFF_000F) | (($urandom % 4) << 4) | (($urandom % 4) << 24);
          1: d = $urandom % 2;
          2: d = $urandom % 16;
          default: d = (($urandom % 8) == 0) ? 32'hFFFF_FFFF : $urandom % 16;
        endcase
        wr(b_addr, d);
      end else if (r < 24) rd(2'($urandom % 4));
      else step();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule